// File: doc/BRIEF.md
# Direct Four-Level Symbol Serializer

This block converts between host bytes and two-bit codes for a four-level FSK channel when no framing, error coding or interleaving is applied. In transmit mode a started task hands bytes out as symbol codes, one per pulse of the symbol-rate strobe, with the most significant bit pair first. A task can move one byte (four symbols), a burst of six bytes (twenty-four symbols), or a single channel-status symbol. In receive mode the same tasks do the reverse. Four sliced symbol codes are packed into one byte, and a single received status symbol is captured with its own ready flag and an optional interrupt.

The symbol interface carries a two-bit code and a separate mid-level flag. When the flag is set the modulator is held at its centre (bias) level. The flag is held for the first eight strobes after the block changes from receive to transmit, so the downstream pulse-shaping filter can settle. It is also held whenever no transmit symbol is due. An optional polarity inversion negates every level, both on the way out and on the way in.

Top module: `qsym_serdes`

## Requirements
- R1: After a synchronous active-low reset, `sym_mid` is 1. `task_busy`, `task_done`, `byte_req`, `byte_vld`, `ss_rdy` and `irq` are all 0.
- R2: `sym_out` codes the levels as 11=+3, 10=+1, 00=-1, 01=-3. A one-byte transmit task (`task_kind`=0) emits bits 7:6, then 5:4, then 3:2, then 1:0, one per strobe. Each code appears in the cycle after its strobe, with `sym_mid`=0, and is held until the next strobe.
- R3: A burst task (`task_kind`=1) emits 24 symbols from six bytes. The first byte is taken from `byte_in` when the task is accepted. `byte_req` pulses for one cycle after the strobe that carries the last symbol of each non-final byte. The next byte is read from `byte_in` at the following strobe.
- R4: `task_done` pulses for one cycle after the strobe of a task's final symbol, and `task_busy` falls in the same cycle. A `task_start` while busy is ignored.
- R5: After `tx_mode` changes from 0 to 1, the first 8 strobes keep `sym_mid`=1 and emit nothing. Symbols begin at the 9th strobe. In receive mode `sym_mid` is 1. In transmit mode, a strobe that carries no symbol sets `sym_mid` to 1.
- R6: A receive byte task packs four strobed `sym_in` codes into `byte_out`, the first code in bits 7:6. `byte_vld` and `task_done` pulse together in the cycle after the 4th strobe.
- R7: A transmit status task (`task_kind`=2) emits `ss_code` as one symbol. Its meaning is 11 busy, 01 idle, 10 or 00 unknown.
- R8: A receive status task stores the strobed code in `ss_val` and sets `ss_rdy`, in the same cycle as `task_done`. `ss_rdy` clears when the next task is accepted. `irq` equals `ss_rdy` AND `ss_irq_en`.
- R9: With `inv_en`=1, bit 1 of each code is flipped, which negates the level. This applies to transmitted data and status symbols and to received `sym_in` codes.
- R10: A change of `tx_mode` while busy ends the task in the next cycle, with no `task_done`, no `byte_vld` and no further symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_stb | input | 1 | One-cycle pulse at the symbol rate |
| tx_mode | input | 1 | 1 transmit, 0 receive |
| inv_en | input | 1 | Negate symbol polarity in both directions |
| task_start | input | 1 | Start a task (accepted when not busy) |
| task_kind | input | 2 | 0 one byte, 1 six-byte burst, 2 status symbol, 3 treated as 0 |
| task_busy | output | 1 | Task in progress |
| task_done | output | 1 | One-cycle end-of-task pulse |
| byte_in | input | 8 | Transmit byte from host |
| byte_req | output | 1 | Next burst byte wanted before the next strobe |
| byte_out | output | 8 | Received byte |
| byte_vld | output | 1 | One-cycle pulse, `byte_out` updated |
| sym_out | output | 2 | Transmit symbol code |
| sym_mid | output | 1 | Hold modulator at mid (bias) level |
| sym_in | input | 2 | Sliced received symbol code |
| ss_code | input | 2 | Status symbol to transmit |
| ss_val | output | 2 | Last received status symbol |
| ss_rdy | output | 1 | Received status symbol waiting |
| ss_irq_en | input | 1 | Allow `ss_rdy` onto `irq` |
| irq | output | 1 | Interrupt request |

## Verification
A slip in the within-byte symbol counter shows at `sym_out` on the very next strobe as a code taken from the wrong bit pair. For burst tasks it also shows as a `byte_req` pulse or a `task_done` pulse landing one strobe early or late. A wrong settling count shows as `sym_mid` falling at the wrong strobe after entering transmit, so an off-by-one is visible within nine strobes. A receive packing error is visible only when `byte_vld` pulses, four strobes after the task starts. A lost or stale status flag shows on `ss_rdy` and `irq` in the cycle after the status strobe, or after the next task start.

// File: rtl/qsym_pkg.sv
// Shared types and helpers for the four-level symbol serializer.
// Assumes symbols are two-bit codes whose bit 1 carries the sign.
package qsym_pkg;
    localparam int SYM_W = 2;

    typedef enum logic [1:0] {
        JOB_BYTE  = 2'd0,
        JOB_BURST = 2'd1,
        JOB_STAT  = 2'd2,
        JOB_RSVD  = 2'd3
    } job_e;

    // Level codes: 11 +3, 10 +1, 00 -1, 01 -3
    localparam logic [1:0] LVL_P3 = 2'b11;
    localparam logic [1:0] LVL_P1 = 2'b10;
    localparam logic [1:0] LVL_M1 = 2'b00;
    localparam logic [1:0] LVL_M3 = 2'b01;

    // Negating a level in this code only flips bit 1.
    function automatic logic [1:0] pol_apply(input logic [1:0] code, input logic inv);
        return code ^ {inv, 1'b0};
    endfunction
endpackage

// File: rtl/qsym_warmup.sv
// Settling counter: after entry to transmit mode, counts WARM_SYMS strobes
// before symbols may be emitted. Held at full count while in receive mode.
module qsym_warmup #(
    parameter int WARM_SYMS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic mode_tx,
    output logic warm_ok
);
    localparam int CW = $clog2(WARM_SYMS + 1);

    logic [CW-1:0] cnt;

    // Reload in receive mode, count strobes down in transmit mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(WARM_SYMS);
        end else if (!mode_tx) begin
            cnt <= CW'(WARM_SYMS);
        end else if (stb && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign warm_ok = (cnt == '0);

    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_tx && !stb) |=> $stable(cnt));
endmodule

// File: rtl/qsym_seq.sv
// Task sequencer: accepts a task, counts symbols within a byte and bytes
// within a burst, and produces the step strobe, byte request and done pulse.
// Assumes sym_stb is a single-cycle pulse and tx_mode is normally stable
// during a task; a change aborts the task.
module qsym_seq
    import qsym_pkg::*;
#(
    parameter int SYMS_PER_BYTE = 4,
    parameter int BURST_BYTES   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    input  logic       start,
    input  logic [1:0] kind,
    input  logic       mode_tx,
    input  logic       warm_ok,
    output logic       accept,
    output logic       busy,
    output logic       step,
    output logic       stat,
    output logic       first,
    output logic       idx0,
    output logic       sym_last,
    output logic       done,
    output logic       byte_req
);
    localparam int IW = (SYMS_PER_BYTE > 1) ? $clog2(SYMS_PER_BYTE) : 1;
    localparam int LW = $clog2(BURST_BYTES + 1);

    logic          mode_q;
    logic          abort;
    logic          task_last;
    logic [IW-1:0] idx;
    logic [LW-1:0] left;
    job_e          job;

    assign job       = job_e'(kind);
    assign abort     = busy && (mode_tx != mode_q);
    assign accept    = start && !busy;
    assign step      = stb && busy && !abort && (!mode_tx || warm_ok);
    assign sym_last  = (idx == IW'(SYMS_PER_BYTE - 1));
    assign idx0      = (idx == '0);
    assign task_last = stat || (sym_last && left == '0);

    // Remember the mode so a change during a task can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_tx;
    end

    // Task state: acceptance, symbol/byte counting, completion and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            stat     <= 1'b0;
            first    <= 1'b0;
            idx      <= '0;
            left     <= '0;
            done     <= 1'b0;
            byte_req <= 1'b0;
        end else begin
            done     <= 1'b0;
            byte_req <= 1'b0;
            if (accept) begin
                busy  <= 1'b1;
                stat  <= (job == JOB_STAT);
                left  <= (job == JOB_BURST) ? LW'(BURST_BYTES - 1) : '0;
                idx   <= '0;
                first <= 1'b1;
            end else if (abort) begin
                busy <= 1'b0;
            end else if (step) begin
                first <= 1'b0;
                if (task_last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (sym_last) begin
                    idx      <= '0;
                    left     <= left - 1'b1;
                    byte_req <= mode_tx;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> busy);
    p_req_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> $past(mode_tx));
    p_abort_nodone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !done && !busy);
endmodule

// File: rtl/qsym_txpath.sv
// Transmit datapath: shifts bytes out MSB pair first, or sends the status
// code, applies polarity, and drives the mid-level flag.
// Assumes byte_in holds the next burst byte at the strobe after byte_req.
module qsym_txpath
    import qsym_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              mode_tx,
    input  logic              inv,
    input  logic              accept,
    input  logic              step,
    input  logic              stat,
    input  logic              first,
    input  logic              idx0,
    input  logic [DATA_W-1:0] byte_in,
    input  logic [1:0]        ss_code,
    output logic [1:0]        sym_out,
    output logic              sym_mid
);
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] src;

    // Pick the fresh host byte at the start of every non-first byte.
    always_comb begin
        src = (idx0 && !first) ? byte_in : sh;
    end

    // Shift register: latch first byte on accept, shift on each data step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (accept) begin
            sh <= byte_in;
        end else if (step && mode_tx && !stat) begin
            sh <= src << SYM_W;
        end
    end

    // Output register: a symbol on a transmit step, otherwise mid level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_out <= LVL_M1;
            sym_mid <= 1'b1;
        end else if (!mode_tx) begin
            sym_mid <= 1'b1;
        end else if (step) begin
            sym_out <= stat ? pol_apply(ss_code, inv)
                            : pol_apply(src[DATA_W-1 -: SYM_W], inv);
            sym_mid <= 1'b0;
        end else if (stb) begin
            sym_mid <= 1'b1;
        end
    end

    p_sym_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && mode_tx) |=> $stable(sym_out) && $stable(sym_mid));
endmodule

// File: rtl/qsym_rxpath.sv
// Receive datapath: removes polarity, packs symbols into bytes, and captures
// a single status symbol with a ready flag cleared on the next task.
module qsym_rxpath
    import qsym_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_tx,
    input  logic              inv,
    input  logic              accept,
    input  logic              step,
    input  logic              stat,
    input  logic              sym_last,
    input  logic [1:0]        sym_in,
    output logic [DATA_W-1:0] byte_out,
    output logic              byte_vld,
    output logic [1:0]        ss_val,
    output logic              ss_rdy
);
    logic [DATA_W-1:0] sh;
    logic [1:0]        d;
    logic [DATA_W-1:0] nxt;

    assign d   = pol_apply(sym_in, inv);
    assign nxt = {sh[DATA_W-SYM_W-1:0], d};

    // Symbol packing and byte delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            byte_out <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (step && !mode_tx && !stat) begin
                sh <= nxt;
                if (sym_last) begin
                    byte_out <= nxt;
                    byte_vld <= 1'b1;
                end
            end
        end
    end

    // Status symbol capture and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_val <= LVL_M1;
            ss_rdy <= 1'b0;
        end else if (accept) begin
            ss_rdy <= 1'b0;
        end else if (step && !mode_tx && stat) begin
            ss_val <= d;
            ss_rdy <= 1'b1;
        end
    end

    p_vld_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> !$past(mode_tx));
    p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

// File: rtl/qsym_serdes.sv
// Top of the direct four-level symbol serializer. Connects the settling
// counter, task sequencer and the two datapaths; forms the interrupt.
// Assumes one task at a time and a symbol strobe at most every other cycle
// when a burst is fed through byte_req.
module qsym_serdes #(
    parameter int DATA_W      = 8,
    parameter int BURST_BYTES = 6,
    parameter int WARM_SYMS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_stb,
    input  logic              tx_mode,
    input  logic              inv_en,
    input  logic              task_start,
    input  logic [1:0]        task_kind,
    output logic              task_busy,
    output logic              task_done,
    input  logic [DATA_W-1:0] byte_in,
    output logic              byte_req,
    output logic [DATA_W-1:0] byte_out,
    output logic              byte_vld,
    output logic [1:0]        sym_out,
    output logic              sym_mid,
    input  logic [1:0]        sym_in,
    input  logic [1:0]        ss_code,
    output logic [1:0]        ss_val,
    output logic              ss_rdy,
    input  logic              ss_irq_en,
    output logic              irq
);
    localparam int SPB = DATA_W / qsym_pkg::SYM_W;

    logic warm_ok;
    logic accept;
    logic step;
    logic stat;
    logic first;
    logic idx0;
    logic sym_last;

    qsym_warmup #(.WARM_SYMS(WARM_SYMS)) u_warm (
        .clk(clk), .rst_n(rst_n), .stb(sym_stb), .mode_tx(tx_mode),
        .warm_ok(warm_ok)
    );

    qsym_seq #(.SYMS_PER_BYTE(SPB), .BURST_BYTES(BURST_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .stb(sym_stb), .start(task_start),
        .kind(task_kind), .mode_tx(tx_mode), .warm_ok(warm_ok),
        .accept(accept), .busy(task_busy), .step(step), .stat(stat),
        .first(first), .idx0(idx0), .sym_last(sym_last),
        .done(task_done), .byte_req(byte_req)
    );

    qsym_txpath #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .stb(sym_stb), .mode_tx(tx_mode),
        .inv(inv_en), .accept(accept), .step(step), .stat(stat),
        .first(first), .idx0(idx0), .byte_in(byte_in), .ss_code(ss_code),
        .sym_out(sym_out), .sym_mid(sym_mid)
    );

    qsym_rxpath #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode_tx(tx_mode), .inv(inv_en),
        .accept(accept), .step(step), .stat(stat), .sym_last(sym_last),
        .sym_in(sym_in), .byte_out(byte_out), .byte_vld(byte_vld),
        .ss_val(ss_val), .ss_rdy(ss_rdy)
    );

    // Interrupt request from a waiting status symbol.
    always_comb begin
        irq = ss_rdy && ss_irq_en;
    end

    p_warm_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_ok |-> sym_mid);
    p_rx_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mode |=> sym_mid);
    p_rdy_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_rdy) |-> task_done);
endmodule

// File: tb/sim_qsym_serdes.sv
module sim_qsym_serdes;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_stb = 1'b0;
    logic       tx_mode = 1'b0;
    logic       inv_en = 1'b0;
    logic       task_start = 1'b0;
    logic [1:0] task_kind = 2'd0;
    logic       task_busy;
    logic       task_done;
    logic [7:0] byte_in = 8'h00;
    logic       byte_req;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic [1:0] sym_out;
    logic       sym_mid;
    logic [1:0] sym_in = 2'b00;
    logic [1:0] ss_code = 2'b00;
    logic [1:0] ss_val;
    logic       ss_rdy;
    logic       ss_irq_en = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    logic s_done, s_req, s_vld;

    always #10 clk = ~clk;

    qsym_serdes u0 (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .tx_mode(tx_mode),
        .inv_en(inv_en), .task_start(task_start), .task_kind(task_kind),
        .task_busy(task_busy), .task_done(task_done), .byte_in(byte_in),
        .byte_req(byte_req), .byte_out(byte_out), .byte_vld(byte_vld),
        .sym_out(sym_out), .sym_mid(sym_mid), .sym_in(sym_in),
        .ss_code(ss_code), .ss_val(ss_val), .ss_rdy(ss_rdy),
        .ss_irq_en(ss_irq_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [1:0] rxs);
        @(negedge clk);
        sym_in  = rxs;
        sym_stb = 1'b1;
        @(negedge clk);
        sym_stb = 1'b0;
        s_done = task_done;
        s_req  = byte_req;
        s_vld  = byte_vld;
    endtask

    task automatic start_job(input logic [1:0] k);
        @(negedge clk);
        task_start = 1'b1;
        task_kind  = k;
        @(negedge clk);
        task_start = 1'b0;
    endtask

    function automatic logic [1:0] pair(input logic [7:0] b, input int k, input logic inv);
        return ((b >> (6 - 2 * k)) & 8'h3) ^ {inv, 1'b0};
    endfunction

    // R1: reset state
    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mid", sym_mid, 1);
        chk("R1 busy", task_busy, 0);
        chk("R1 done", task_done, 0);
        chk("R1 req", byte_req, 0);
        chk("R1 vld", byte_vld, 0);
        chk("R1 rdy", ss_rdy, 0);
        chk("R1 irq", irq, 0);
    endtask

    // R5 settling then R2/R4 single byte transmit
    task automatic t_tx_byte_warm();
        @(negedge clk);
        tx_mode = 1'b1;
        byte_in = 8'hB4;
        start_job(2'd0);
        byte_in = 8'h00;
        for (int i = 0; i < 8; i++) begin
            strobe(2'b00);
            chk("R5 mid during settle", sym_mid, 1);
            chk("R5 no done during settle", s_done, 0);
        end
        for (int k = 0; k < 4; k++) begin
            strobe(2'b00);
            chk("R2 symbol", sym_out, pair(8'hB4, k, 1'b0));
            chk("R2 mid low", sym_mid, 0);
            chk("R4 done timing", s_done, (k == 3));
        end
        chk("R4 busy falls", task_busy, 0);
        @(negedge clk);
        chk("R2 hold", sym_out, pair(8'hB4, 3, 1'b0));
        strobe(2'b00);
        chk("R5 mid after task", sym_mid, 1);
    endtask

    // R3 burst with byte requests; R4 start while busy ignored
    task automatic t_burst();
        logic [7:0] bb [6];
        bb[0] = 8'h1B; bb[1] = 8'hE4; bb[2] = 8'h00;
        bb[3] = 8'hFF; bb[4] = 8'h5A; bb[5] = 8'hC3;
        byte_in = bb[0];
        start_job(2'd1);
        for (int j = 0; j < 24; j++) begin
            strobe(2'b00);
            chk("R3 burst symbol", sym_out, pair(bb[j / 4], j % 4, 1'b0));
            chk("R3 byte_req", s_req, ((j % 4 == 3) && (j < 23)));
            chk("R4 burst done", s_done, (j == 23));
            if (j % 4 == 3 && j < 23) byte_in = bb[j / 4 + 1];
            if (j == 10) start_job(2'd2);
        end
        chk("R4 idle after burst", task_busy, 0);
    endtask

    // R9 inversion on transmit data and status; R7 status symbol
    task automatic t_tx_inv_stat();
        inv_en  = 1'b1;
        byte_in = 8'hB4;
        start_job(2'd0);
        for (int k = 0; k < 4; k++) begin
            strobe(2'b00);
            chk("R9 inverted tx", sym_out, pair(8'hB4, k, 1'b1));
        end
        inv_en  = 1'b0;
        ss_code = 2'b01;
        start_job(2'd2);
        strobe(2'b00);
        chk("R7 status idle code", sym_out, 2'b01);
        chk("R7 status done", s_done, 1);
        ss_code = 2'b11;
        inv_en  = 1'b1;
        start_job(2'd2);
        strobe(2'b00);
        chk("R9 inverted status", sym_out, 2'b01);
        inv_en = 1'b0;
    endtask

    // R6 receive packing, with and without inversion
    task automatic t_rx_byte();
        logic [1:0] seq [4];
        seq[0] = 2'b01; seq[1] = 2'b10; seq[2] = 2'b11; seq[3] = 2'b00;
        @(negedge clk);
        tx_mode = 1'b0;
        @(negedge clk);
        chk("R5 mid in rx", sym_mid, 1);
        start_job(2'd0);
        for (int k = 0; k < 4; k++) begin
            strobe(seq[k]);
            chk("R6 vld timing", s_vld, (k == 3));
            chk("R6 done timing", s_done, (k == 3));
        end
        chk("R6 byte", byte_out, 8'h6C);
        inv_en = 1'b1;
        start_job(2'd0);
        for (int k = 0; k < 4; k++) strobe(seq[k]);
        chk("R9 inverted rx", byte_out, 8'hC6);
        inv_en = 1'b0;
    endtask

    // R8 status capture, irq gating, clear on next task
    task automatic t_rx_stat();
        ss_irq_en = 1'b1;
        start_job(2'd2);
        strobe(2'b10);
        chk("R8 ss_val", ss_val, 2'b10);
        chk("R8 ss_rdy", ss_rdy, 1);
        chk("R8 done", s_done, 1);
        chk("R8 irq on", irq, 1);
        ss_irq_en = 1'b0;
        #1;
        chk("R8 irq masked", irq, 0);
        start_job(2'd0);
        chk("R8 rdy cleared", ss_rdy, 0);
        for (int k = 0; k < 4; k++) strobe(2'b00);
        inv_en = 1'b1;
        start_job(2'd2);
        strobe(2'b11);
        chk("R9 inverted status rx", ss_val, 2'b01);
        inv_en = 1'b0;
    endtask

    // R10 abort on mode change, then settle and transmit
    task automatic t_abort();
        start_job(2'd0);
        strobe(2'b11);
        strobe(2'b11);
        @(negedge clk);
        tx_mode = 1'b1;
        @(negedge clk);
        chk("R10 abort busy", task_busy, 0);
        chk("R10 abort no done", task_done, 0);
        chk("R10 abort no vld", byte_vld, 0);
        byte_in = 8'h27;
        start_job(2'd0);
        for (int i = 0; i < 8; i++) strobe(2'b00);
        chk("R5 still mid at 8th", sym_mid, 1);
        strobe(2'b00);
        chk("R5 first symbol at 9th", sym_out, 2'b00);
        chk("R5 mid low at 9th", sym_mid, 0);
    endtask

    initial begin
        t_reset();
        t_tx_byte_warm();
        t_burst();
        t_tx_inv_stat();
        t_rx_byte();
        t_rx_stat();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule